// File: doc/BRIEF.md
# Sleep Wake Event Router

This block gathers three wake and event sources: a ring-indicate line, a PCI power-management-event line and a general-purpose input used as a sleep button. It routes each one to a wake request, an SCI, an SMI, a break event or a sleep request, or drops it. The decision depends on the present system sleep state and on per-source enable and routing bits. Software supplies the present-state code as a 3-bit value: 0 is S0 (working), 1 to 4 are S1 to S4 (suspend), 5 is S5 (soft-off), and 6 and 7 are unused codes that no source acts on.

The ring and PME lines each pass through a two-stage synchronizer and then an edge detector. The ring source fires when its line rises to active. The PME source fires only when its line goes from high to low. The sleep button is also synchronized and feeds a two-state press tracker. `SB_IDLE` moves to `SB_HELD` when the synchronized button is high, and that transition is the press event. `SB_HELD` returns to `SB_IDLE` when the button is low again, so each press yields one event. Every routed output is a registered one-cycle pulse. Each source also keeps a sticky status bit that only a write-one-to-clear strobe clears.

Top module: `wake_evt_router`

## Requirements
- R1: When the ring line rises while the present state is 1 to 5 and `ring_wake_en` is 1, `wake_req` pulses high for exactly one cycle, three rising clock edges after the line changed.
- R2: When the ring line rises in state 0, no wake request is raised for any enable setting. If `ring_int_en` is 1, `brk_evt` pulses for exactly one cycle with the same latency as R1.
- R3: A ring rise in states 1 to 5 with `ring_wake_en` at 0 raises nothing. No `brk_evt` is raised outside state 0. No ring output is raised in state 6 or 7.
- R4: Only a high-to-low transition of `pme_line` is a PME event. A low-to-high transition raises no output and sets no status.
- R5: A PME event pulses `sci_evt` when `pme_route` is 1 and `smi_evt` when it is 2. Codes 0 and 3 route to neither. This applies in every state, and the two outputs are never high together.
- R6: A PME event also pulses `wake_req` when `pme_wake_en` is 1 and the state is 1 to 5.
- R7: A button press in state 0 pulses `slp_req`, with `slp_tgt` equal to `sb_target`, but only when `sb_target` is 1 to 4. Targets 0, 5, 6 and 7 raise nothing. `slp_tgt` reads 0 whenever `slp_req` is low.
- R8: A button press in states 1 to 4 pulses `wake_req` only if `sb_wake_en` is 1. A press in state 5, 6 or 7 never wakes.
- R9: Holding the button produces one event per press. No further output comes until the button has been released and pressed again.
- R10: `evt_sts` holds bit 0 for ring, bit 1 for PME and bit 2 for the button. Each bit is set by its source's event whatever the routing. A bit clears only on a cycle where the matching `sts_clr` bit is 1. If a set and a clear land on the same edge, the set wins.
- R11: During and after reset, all pulse outputs, `slp_tgt` and `evt_sts` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_act | input | 1 | Ring-indicate line, active high, asynchronous |
| pme_line | input | 1 | PME line, idle high, asynchronous |
| sb_line | input | 1 | Sleep button level, high while pressed |
| pstate | input | 3 | Present sleep state code (0 = S0 ... 5 = S5) |
| ring_wake_en | input | 1 | Ring may wake from suspend |
| ring_int_en | input | 1 | Ring in S0 produces a break event |
| pme_route | input | 2 | PME routing: 1 = SCI, 2 = SMI, 0/3 = none |
| pme_wake_en | input | 1 | PME may wake from suspend |
| sb_wake_en | input | 1 | Sleep button may wake from S1 to S4 |
| sb_target | input | 3 | Requested sleep state for the button |
| sts_clr | input | 3 | Write-one-to-clear strobe for the status bits |
| wake_req | output | 1 | Wake request pulse |
| sci_evt | output | 1 | SCI pulse |
| smi_evt | output | 1 | SMI pulse |
| brk_evt | output | 1 | Break event pulse |
| slp_req | output | 1 | Sleep request pulse |
| slp_tgt | output | 3 | Target state accompanying `slp_req` |
| evt_sts | output | 3 | Sticky status: ring, PME, button |

## Verification
The assertions check the following on every cycle: no break event outside S0, no wake request in S0, break and sleep-request pulses that last one cycle, a valid sleep target whenever a request is raised, SCI and SMI never together, and status bits that fall only under a clear strobe. The bench sweeps every present-state code against every enable and routing combination for each source. It computes the expected pulses arithmetically and checks their count and their exact cycle. Only those scenarios can show the three-edge latency, that a PME rise is ignored, one event per held press, and that a set beats a clear on the same edge.

// File: rtl/wake_evt_pkg.sv
package wake_evt_pkg;

    localparam int ST_W    = 3;
    localparam int NSRC    = 3;
    localparam int STS_RING = 0;
    localparam int STS_PME  = 1;
    localparam int STS_SB   = 2;

    typedef enum logic [ST_W-1:0] {
        PS_S0 = 3'd0,
        PS_S1 = 3'd1,
        PS_S2 = 3'd2,
        PS_S3 = 3'd3,
        PS_S4 = 3'd4,
        PS_S5 = 3'd5,
        PS_X6 = 3'd6,
        PS_X7 = 3'd7
    } pstate_t;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_SCI  = 2'd1,
        RT_SMI  = 2'd2,
        RT_RSVD = 2'd3
    } route_t;

    typedef enum logic {
        SB_IDLE = 1'b0,
        SB_HELD = 1'b1
    } sb_state_t;

    function automatic logic is_suspend(input logic [ST_W-1:0] ps);
        return (ps >= PS_S1) && (ps <= PS_S5);
    endfunction

    function automatic logic is_light(input logic [ST_W-1:0] ps);
        return (ps >= PS_S1) && (ps <= PS_S4);
    endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[gi] <= RST_VAL;
                    else     chain_q[gi] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[gi] <= RST_VAL;
                    else     chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/wake_edge.sv
module wake_edge #(
    parameter bit FALLING = 1'b0,
    parameter bit IDLE    = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE;
        else     prev_q <= level;
    end

    generate
        if (FALLING) begin : g_fall
            assign hit = prev_q & ~level;
        end else begin : g_rise
            assign hit = level & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/wake_sb_fsm.sv
module wake_sb_fsm
    import wake_evt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic btn,
    output logic press
);
    sb_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SB_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        press   = 1'b0;
        unique case (state_q)
            SB_IDLE: begin
                if (btn) begin
                    state_d = SB_HELD;
                    press   = 1'b1;
                end
            end
            SB_HELD: begin
                if (!btn) state_d = SB_IDLE;
            end
            default: state_d = SB_IDLE;
        endcase
    end
endmodule

// File: rtl/wake_evt_router.sv
module wake_evt_router
    import wake_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ring_act,
    input  logic            pme_line,
    input  logic            sb_line,
    input  logic [ST_W-1:0] pstate,
    input  logic            ring_wake_en,
    input  logic            ring_int_en,
    input  logic [1:0]      pme_route,
    input  logic            pme_wake_en,
    input  logic            sb_wake_en,
    input  logic [ST_W-1:0] sb_target,
    input  logic [NSRC-1:0] sts_clr,
    output logic            wake_req,
    output logic            sci_evt,
    output logic            smi_evt,
    output logic            brk_evt,
    output logic            slp_req,
    output logic [ST_W-1:0] slp_tgt,
    output logic [NSRC-1:0] evt_sts
);
    localparam logic [NSRC-1:0] SYNC_IDLE = NSRC'(1) << STS_PME;

    logic [NSRC-1:0] raw_in, sync_out;
    logic            ring_hit, pme_hit, sb_hit;

    always_comb begin
        raw_in           = '0;
        raw_in[STS_RING] = ring_act;
        raw_in[STS_PME]  = pme_line;
        raw_in[STS_SB]   = sb_line;
    end

    wake_sync #(
        .WIDTH   (NSRC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_in),
        .q_out (sync_out)
    );

    wake_edge #(.FALLING(1'b0), .IDLE(1'b0)) u_ring_edge (
        .clk   (clk),
        .rst   (rst),
        .level (sync_out[STS_RING]),
        .hit   (ring_hit)
    );

    wake_edge #(.FALLING(1'b1), .IDLE(1'b1)) u_pme_edge (
        .clk   (clk),
        .rst   (rst),
        .level (sync_out[STS_PME]),
        .hit   (pme_hit)
    );

    wake_sb_fsm u_sb (
        .clk   (clk),
        .rst   (rst),
        .btn   (sync_out[STS_SB]),
        .press (sb_hit)
    );

    // routing decisions
    logic            in_s0, in_susp, in_light, tgt_ok;
    logic            wake_d, sci_d, smi_d, brk_d, slp_d;
    logic [NSRC-1:0] set_vec, sts_d;
    route_t          route;

    always_comb begin
        route    = route_t'(pme_route);
        in_s0    = (pstate == PS_S0);
        in_susp  = is_suspend(pstate);
        in_light = is_light(pstate);
        tgt_ok   = is_light(sb_target);

        wake_d = (ring_hit & in_susp  & ring_wake_en)
               | (pme_hit  & in_susp  & pme_wake_en)
               | (sb_hit   & in_light & sb_wake_en);
        sci_d  = pme_hit & (route == RT_SCI);
        smi_d  = pme_hit & (route == RT_SMI);
        brk_d  = ring_hit & in_s0 & ring_int_en;
        slp_d  = sb_hit & in_s0 & tgt_ok;

        set_vec           = '0;
        set_vec[STS_RING] = ring_hit;
        set_vec[STS_PME]  = pme_hit;
        set_vec[STS_SB]   = sb_hit;
        sts_d = (evt_sts & ~sts_clr) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_req <= 1'b0;
            sci_evt  <= 1'b0;
            smi_evt  <= 1'b0;
            brk_evt  <= 1'b0;
            slp_req  <= 1'b0;
            slp_tgt  <= '0;
            evt_sts  <= '0;
        end else begin
            wake_req <= wake_d;
            sci_evt  <= sci_d;
            smi_evt  <= smi_d;
            brk_evt  <= brk_d;
            slp_req  <= slp_d;
            slp_tgt  <= slp_d ? sb_target : '0;
            evt_sts  <= sts_d;
        end
    end
endmodule

// File: rtl/wake_evt_router_chk.sv
module wake_evt_router_chk
    import wake_evt_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [ST_W-1:0] pstate,
    input logic [NSRC-1:0] sts_clr,
    input logic            wake_req,
    input logic            sci_evt,
    input logic            smi_evt,
    input logic            brk_evt,
    input logic            slp_req,
    input logic [ST_W-1:0] slp_tgt,
    input logic [NSRC-1:0] evt_sts
);
    assert_brk_only_s0_R3: assert property (@(posedge clk) disable iff (rst)
        brk_evt |-> ($past(pstate) == PS_S0));

    assert_brk_single_R2: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> !brk_evt);

    assert_no_wake_s0_R2: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> ($past(pstate) != PS_S0));

    assert_route_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(sci_evt && smi_evt));

    assert_slp_target_R7: assert property (@(posedge clk) disable iff (rst)
        slp_req |-> (slp_tgt >= PS_S1 && slp_tgt <= PS_S4 && $past(pstate) == PS_S0));

    assert_slp_tgt_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !slp_req |-> (slp_tgt == '0));

    assert_slp_single_R9: assert property (@(posedge clk) disable iff (rst)
        slp_req |=> !slp_req);

    assert_sts_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ((~evt_sts & $past(evt_sts) & ~$past(sts_clr)) == '0));
endmodule

bind wake_evt_router wake_evt_router_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pstate   (pstate),
    .sts_clr  (sts_clr),
    .wake_req (wake_req),
    .sci_evt  (sci_evt),
    .smi_evt  (smi_evt),
    .brk_evt  (brk_evt),
    .slp_req  (slp_req),
    .slp_tgt  (slp_tgt),
    .evt_sts  (evt_sts)
);

// File: tb/wake_evt_router_bench.sv
`timescale 1ns/1ps
module wake_evt_router_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ring_act = 1'b0, pme_line = 1'b1, sb_line = 1'b0;
    logic [2:0] pstate = 3'd0;
    logic       ring_wake_en = 1'b0, ring_int_en = 1'b0;
    logic [1:0] pme_route = 2'd0;
    logic       pme_wake_en = 1'b0, sb_wake_en = 1'b0;
    logic [2:0] sb_target = 3'd0;
    logic [2:0] sts_clr = 3'd0;
    logic       wake_req, sci_evt, smi_evt, brk_evt, slp_req;
    logic [2:0] slp_tgt, evt_sts;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    // pulse counts and first-seen index for the last observation window
    int c_wake, c_sci, c_smi, c_brk, c_slp, f_any;
    logic [2:0] tgt_seen;

    always #2.5 clk = ~clk;

    wake_evt_router u_wake_evt_router (
        .clk(clk), .rst(rst), .ring_act(ring_act), .pme_line(pme_line),
        .sb_line(sb_line), .pstate(pstate), .ring_wake_en(ring_wake_en),
        .ring_int_en(ring_int_en), .pme_route(pme_route),
        .pme_wake_en(pme_wake_en), .sb_wake_en(sb_wake_en),
        .sb_target(sb_target), .sts_clr(sts_clr), .wake_req(wake_req),
        .sci_evt(sci_evt), .smi_evt(smi_evt), .brk_evt(brk_evt),
        .slp_req(slp_req), .slp_tgt(slp_tgt), .evt_sts(evt_sts)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d (ps=%0d)", req, act, exp, pstate);
        end
    endtask

    // observe six cycles after a stimulus applied at the current negedge
    task automatic observe();
        c_wake = 0; c_sci = 0; c_smi = 0; c_brk = 0; c_slp = 0;
        f_any = 0; tgt_seen = 3'd0;
        for (int i = 1; i <= 6; i++) begin
            @(posedge clk); @(negedge clk);
            if (wake_req || sci_evt || smi_evt || brk_evt || slp_req)
                if (f_any == 0) f_any = i;
            c_wake += int'(wake_req);
            c_sci  += int'(sci_evt);
            c_smi  += int'(smi_evt);
            c_brk  += int'(brk_evt);
            c_slp  += int'(slp_req);
            if (slp_req) tgt_seen = slp_tgt;
        end
    endtask

    task automatic clear_all();
        sts_clr = 3'b111;
        @(negedge clk);
        sts_clr = 3'b000;
    endtask

    function automatic bit susp(input int ps);
        return ps >= 1 && ps <= 5;
    endfunction

    function automatic bit light(input int v);
        return v >= 1 && v <= 4;
    endfunction

    initial begin : watchdog
        for (int k = 0; k < 150000; k++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_errs++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        check("R11 wake", int'(wake_req), 0);
        check("R11 pulses", int'({sci_evt, smi_evt, brk_evt, slp_req}), 0);
        check("R11 sts", int'(evt_sts), 0);
        check("R11 tgt", int'(slp_tgt), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 after release", int'({wake_req, sci_evt, smi_evt, brk_evt, slp_req, evt_sts}), 0);

        // Ring sweep: R1, R2, R3, R10
        for (int ps = 0; ps < 8; ps++)
            for (int cfg = 0; cfg < 4; cfg++) begin
                int ew, eb;
                pstate = 3'(ps);
                ring_wake_en = cfg[0];
                ring_int_en  = cfg[1];
                clear_all();
                ew = (susp(ps) && cfg[0]) ? 1 : 0;
                eb = (ps == 0 && cfg[1]) ? 1 : 0;
                ring_act = 1'b1;
                observe();
                check("R1 ring wake count", c_wake, ew);
                check("R2 ring break count", c_brk, eb);
                check("R3 ring no pme/sleep outputs", c_sci + c_smi + c_slp, 0);
                if (ew + eb > 0) check("R1 ring latency", f_any, 3);
                check("R10 ring status", int'(evt_sts), 1);
                ring_act = 1'b0;
                repeat (4) @(negedge clk);
            end
        ring_wake_en = 1'b0; ring_int_en = 1'b0;

        // PME sweep: R4, R5, R6, R10
        for (int ps = 0; ps < 8; ps++)
            for (int cfg = 0; cfg < 8; cfg++) begin
                int ew, es, em;
                pstate = 3'(ps);
                pme_route   = cfg[1:0];
                pme_wake_en = cfg[2];
                clear_all();
                ew = (susp(ps) && cfg[2]) ? 1 : 0;
                es = (cfg[1:0] == 2'd1) ? 1 : 0;
                em = (cfg[1:0] == 2'd2) ? 1 : 0;
                pme_line = 1'b0;
                observe();
                check("R6 pme wake count", c_wake, ew);
                check("R5 pme sci count", c_sci, es);
                check("R5 pme smi count", c_smi, em);
                if (ew + es + em > 0) check("R4 pme latency", f_any, 3);
                check("R10 pme status", int'(evt_sts), 2);
                clear_all();
                pme_line = 1'b1;
                observe();
                check("R4 rise no output", c_wake + c_sci + c_smi + c_brk + c_slp, 0);
                check("R4 rise no status", int'(evt_sts), 0);
            end
        pme_route = 2'd0; pme_wake_en = 1'b0;

        // Sleep button sweep: R7, R8, R9, R10
        for (int ps = 0; ps < 8; ps++)
            for (int tg = 0; tg < 8; tg++)
                for (int we = 0; we < 2; we++) begin
                    int es, ew;
                    pstate = 3'(ps);
                    sb_target = 3'(tg);
                    sb_wake_en = we[0];
                    clear_all();
                    es = (ps == 0 && light(tg)) ? 1 : 0;
                    ew = (light(ps) && we == 1) ? 1 : 0;
                    sb_line = 1'b1;
                    observe();
                    check("R7 sleep request count", c_slp, es);
                    check("R8 button wake count", c_wake, ew);
                    if (es == 1) begin
                        check("R7 sleep target", int'(tgt_seen), tg);
                        check("R7 sleep latency", f_any, 3);
                    end
                    check("R10 button status", int'(evt_sts), 4);
                    observe();
                    check("R9 held no repeat", c_slp + c_wake, 0);
                    sb_line = 1'b0;
                    repeat (4) @(negedge clk);
                end

        // Second press after release gives a new event (R9)
        pstate = 3'd0; sb_target = 3'd3;
        sb_line = 1'b1;
        observe();
        check("R9 first press", c_slp, 1);
        sb_line = 1'b0;
        repeat (4) @(negedge clk);
        sb_line = 1'b1;
        observe();
        check("R9 second press", c_slp, 1);
        sb_line = 1'b0;
        repeat (4) @(negedge clk);

        // Sticky clearing per bit (R10)
        clear_all();
        pstate = 3'd5;
        ring_act = 1'b1; pme_line = 1'b0; sb_line = 1'b1;
        observe();
        check("R10 all set", int'(evt_sts), 7);
        ring_act = 1'b0; pme_line = 1'b1; sb_line = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 holds without clear", int'(evt_sts), 7);
        sts_clr = 3'b010;
        @(negedge clk);
        sts_clr = 3'b000;
        check("R10 clear pme only", int'(evt_sts), 5);
        sts_clr = 3'b000;
        repeat (2) @(negedge clk);
        check("R10 zero mask no effect", int'(evt_sts), 5);

        // Set wins over a same-edge clear (R10)
        clear_all();
        check("R10 cleared", int'(evt_sts), 0);
        ring_act = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        sts_clr = 3'b001;
        @(posedge clk); @(negedge clk);
        sts_clr = 3'b000;
        check("R10 set beats clear", int'(evt_sts), 1);
        ring_act = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule